// File: doc/BRIEF.md
# Conversion Cycle and Serial Readout Controller

This block runs one analog-to-digital conversion cycle at a time and returns the result to a host over a three-wire serial link. The host pulls its convert-start line low to begin a cycle. At that moment the block captures the channel-select input and hands it to the decimation filter, along with a one-cycle start pulse. It then waits for the filter to deliver a 15-bit result. The host clocks that result out, most significant bit first, with a serial clock, and then raises convert-start to close the cycle.

The serial data line also reports status. While it is idle it is not driven. During the conversion it is driven low, and it is driven high once the result is ready. During readout it carries the result bits, which change on falling serial-clock edges. After the last bit it returns low, and it is released again when convert-start goes high. If convert-start rises early, whether before the result arrives or in the middle of the word, the cycle is abandoned and the line floats.

All host pins are asynchronous to the block clock. Each one passes through a synchronizer before its edges are detected. The decimation filter lives in the block clock domain and is outside this block.

Top module: `conv_readout`

## Requirements
- R1: After synchronous reset the data line is released (`sdat_oe`=0), no start pulse is issued, and `conv_chan` is 0.
- R2: A falling edge on `cs_n` while idle issues exactly one `conv_start` pulse. From then on the line is driven low (`sdat_oe`=1, `sdat_o`=0) until a result arrives.
- R3: The level of `chan_sel` at the `cs_n` falling edge is latched onto `conv_chan`: 0 selects channel 1 and 1 selects channel 2. Later changes of `chan_sel` during the cycle do not alter `conv_chan`.
- R4: A `res_valid` pulse while the line is driven low captures `res_data`, and the line goes high. It stays high until the first falling edge of `sclk`.
- R5: The k-th falling edge of `sclk` after ready (k = 1..15) presents result bit 15-k, so bit 14 comes first. The line holds that bit until the next falling edge.
- R6: The 16th falling edge drives the line low, and the line stays low while `cs_n` is low. The line is released once `cs_n` rises.
- R7: A rise of `cs_n` before the result arrives, or in the middle of the word, releases the line and returns to idle. A following `cs_n` fall starts a fresh cycle.
- R8: A `res_valid` pulse outside the waiting phase is ignored. In idle it does not make the next cycle ready. During readout it does not change the bits still to be sent.
- R9: Falling `sclk` edges while waiting for the result have no effect. The line stays low, and the readout that follows still starts with bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Convert-start / chip select from host, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous; bits advance on its falling edge |
| chan_sel | input | 1 | Channel choice for the next cycle: 0 = channel 1, 1 = channel 2 |
| res_valid | input | 1 | One-cycle pulse from the decimation filter marking `res_data` valid |
| res_data | input | 15 | Conversion result |
| conv_start | output | 1 | One-cycle pulse to the filter at the start of a cycle |
| conv_chan | output | 1 | Channel latched for the current cycle |
| sdat_o | output | 1 | Serial data/status value |
| sdat_oe | output | 1 | Output enable of the serial data pad; 0 means high impedance |

## Verification
The assertions check four things on every cycle. A start from idle drives the line low, and an early or closing `cs_n` rise always releases it. The latched channel cannot move during a cycle, and the ready level and each presented bit hold steady between `sclk` falling edges. The bit counter also never advances past the last bit.

Some behaviours only the bench's scenarios can show. These are the MSB-first bit order against known result words, the low level after the 16th edge, and that stray result pulses and early clock edges leave the later readout untouched. The bench also confirms that one `cs_n` fall yields exactly one start pulse and that a fresh cycle works after an abort.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_READY,
        ST_SHIFT,
        ST_DONE
    } cyc_state_e;

    typedef struct packed {
        logic oe;
        logic val;
    } line_drv_t;

    function automatic line_drv_t line_for(cyc_state_e st, logic bit_now);
        line_drv_t d;
        case (st)
            ST_IDLE:  d = '{oe: 1'b0, val: 1'b0};
            ST_BUSY:  d = '{oe: 1'b1, val: 1'b0};
            ST_READY: d = '{oe: 1'b1, val: 1'b1};
            ST_SHIFT: d = '{oe: 1'b1, val: bit_now};
            default:  d = '{oe: 1'b1, val: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/conv_readout_sync.sv
module conv_readout_sync #(
    parameter int          STAGES  = 2,
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[i]}};
                prev  <= RST_VAL[i];
            end else begin
                if (STAGES > 1) chain <= {chain[STAGES-2:0], din[i]};
                else            chain <= din[i];
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl[i]  = chain[STAGES-1];
        assign rise[i] = ~prev &  chain[STAGES-1];
        assign fall[i] =  prev & ~chain[STAGES-1];
    end
endmodule

// File: rtl/conv_readout_shifter.sv
module conv_readout_shifter #(
    parameter int WORD_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              adv,
    output logic              msb,
    output logic              last
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= din;
            cnt <= '0;
        end else if (adv) begin
            sh  <= sh << 1;
            cnt <= cnt + 1'b1;
        end
    end

    assign msb  = sh[WORD_W-1];
    assign last = (cnt == CNT_W'(WORD_W - 1));

    // R5: the sequencer never advances past the final bit
    a_r5_no_adv_past_last: assert property (@(posedge clk) disable iff (rst)
        adv |-> !last);
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W - 1));
endmodule

// File: rtl/conv_readout_seq.sv
module conv_readout_seq
    import conv_readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic       sclk_fall,
    input  logic       chan_lvl,
    input  logic       res_valid,
    input  logic       last,
    output cyc_state_e state,
    output logic       conv_start,
    output logic       conv_chan,
    output logic       load,
    output logic       adv
);
    cyc_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (cs_fall) nxt = ST_BUSY;
            ST_BUSY:  if (cs_rise) nxt = ST_IDLE;
                      else if (res_valid) nxt = ST_READY;
            ST_READY: if (cs_rise) nxt = ST_IDLE;
                      else if (sclk_fall) nxt = ST_SHIFT;
            ST_SHIFT: if (cs_rise) nxt = ST_IDLE;
                      else if (sclk_fall && last) nxt = ST_DONE;
            ST_DONE:  if (cs_rise) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign load = (state == ST_BUSY) && res_valid && !cs_rise;
    assign adv  = (state == ST_SHIFT) && sclk_fall && !cs_rise && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            conv_start <= 1'b0;
            conv_chan  <= 1'b0;
        end else begin
            state      <= nxt;
            conv_start <= (state == ST_IDLE) && cs_fall;
            if ((state == ST_IDLE) && cs_fall) conv_chan <= chan_lvl;
        end
    end

    // R3: channel stays fixed while a cycle is open
    a_r3_chan_held: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(conv_chan));
    // R2: a start pulse is never followed by another one
    a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
endmodule

// File: rtl/conv_readout.sv
module conv_readout
    import conv_readout_pkg::*;
#(
    parameter int WORD_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              chan_sel,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_data,
    output logic              conv_start,
    output logic              conv_chan,
    output logic              sdat_o,
    output logic              sdat_oe
);
    localparam int PIN_N = 3;
    localparam int P_CS  = 0;
    localparam int P_SCK = 1;
    localparam int P_CH  = 2;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
    cyc_state_e       state;
    logic             load, adv, msb, last;
    line_drv_t        drv;

    conv_readout_sync #(
        .STAGES (SYNC_STAGES),
        .N      (PIN_N),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({chan_sel, sclk, cs_n}),
        .lvl (pin_lvl),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    conv_readout_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (pin_fall[P_CS]),
        .cs_rise   (pin_rise[P_CS]),
        .sclk_fall (pin_fall[P_SCK]),
        .chan_lvl  (pin_lvl[P_CH]),
        .res_valid (res_valid),
        .last      (last),
        .state     (state),
        .conv_start(conv_start),
        .conv_chan (conv_chan),
        .load      (load),
        .adv       (adv)
    );

    conv_readout_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk (clk),
        .rst (rst),
        .load(load),
        .din (res_data),
        .adv (adv),
        .msb (msb),
        .last(last)
    );

    assign drv     = line_for(state, msb);
    assign sdat_oe = drv.oe;
    assign sdat_o  = drv.val;

    // R2: starting from idle drives the line low
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && pin_fall[P_CS]) |=> (sdat_oe && !sdat_o));
    // R7 / R6: a chip-select rise always releases the line
    a_r7_rise_releases: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_IDLE) && pin_rise[P_CS]) |=> !sdat_oe);
    // R4: ready level holds until a serial-clock fall
    a_r4_ready_holds: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_READY) && !pin_fall[P_SCK] && !pin_rise[P_CS]) |=> (sdat_oe && sdat_o));
    // R5: a presented bit stays put between falling edges
    a_r5_bit_stable: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SHIFT) && !pin_fall[P_SCK] && !pin_rise[P_CS]) |=> $stable(sdat_o));
endmodule

// File: tb/conv_readout_tb.sv
module conv_readout_tb;
    localparam int W      = 15;
    localparam int SETTLE = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1, sclk = 1'b1, chan_sel = 1'b0;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic         conv_start, conv_chan, sdat_o, sdat_oe;

    int total = 0, bad = 0, starts = 0;
    bit finished = 0;

    localparam logic [1:0] LZ = 2'b00, LL = 2'b10, LH = 2'b11;

    always #4 clk = ~clk;

    conv_readout u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .chan_sel(chan_sel),
        .res_valid(res_valid), .res_data(res_data), .conv_start(conv_start),
        .conv_chan(conv_chan), .sdat_o(sdat_o), .sdat_oe(sdat_oe)
    );

    always @(posedge clk) if (!rst && conv_start) starts++;

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_line(string req, logic [1:0] exp);
        logic [1:0] act;
        act = {sdat_oe, sdat_oe & sdat_o};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s line act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_val(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_result(logic [W-1:0] d);
        @(negedge clk);
        res_data  = d;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        settle();
    endtask

    task automatic start_cycle(logic ch);
        int s0;
        s0 = starts;
        chan_sel = ch;
        settle();
        cs_n = 1'b0;
        settle();
        chk_val("R2 start pulses", starts - s0, 1);
        chk_line("R2 busy low", LL);
        chk_val("R3 channel latched", conv_chan, ch);
    endtask

    task automatic end_cycle();
        cs_n = 1'b1;
        settle();
        chk_line("R6 released after cs high", LZ);
    endtask

    task automatic read_bits(logic [W-1:0] d, int first, int n);
        for (int k = first; k < first + n; k++) begin
            sclk = 1'b0;
            settle();
            chk_line("R5 bit on fall", {1'b1, d[W-k]});
            sclk = 1'b1;
            settle();
            chk_line("R5 bit held", {1'b1, d[W-k]});
        end
    endtask

    task automatic t_reset();
        chk_line("R1 reset released", LZ);
        chk_val("R1 no start", starts, 0);
        chk_val("R1 chan zero", conv_chan, 0);
    endtask

    task automatic t_full_read(logic [W-1:0] d, logic ch);
        start_cycle(ch);
        chan_sel = ~ch;
        settle();
        chk_val("R3 channel held", conv_chan, ch);
        pulse_result(d);
        chk_line("R4 ready high", LH);
        settle();
        chk_line("R4 ready holds", LH);
        read_bits(d, 1, W);
        sclk = 1'b0;
        settle();
        chk_line("R6 low after word", LL);
        sclk = 1'b1;
        settle();
        chk_line("R6 low until cs high", LL);
        end_cycle();
    endtask

    task automatic t_abort_busy();
        start_cycle(1'b0);
        cs_n = 1'b1;
        settle();
        chk_line("R7 abort while busy", LZ);
        t_full_read(15'h1234, 1'b1);
    endtask

    task automatic t_abort_mid();
        logic [W-1:0] d;
        d = 15'h6A3C;
        start_cycle(1'b1);
        pulse_result(d);
        read_bits(d, 1, 5);
        cs_n = 1'b1;
        settle();
        chk_line("R7 abort mid word", LZ);
        t_full_read(15'h0001, 1'b0);
    endtask

    task automatic t_ignore_valid();
        logic [W-1:0] d;
        pulse_result(15'h7FFF);
        chk_line("R8 valid in idle ignored", LZ);
        start_cycle(1'b0);
        chk_line("R8 no stale ready", LL);
        d = 15'h4C71;
        pulse_result(d);
        read_bits(d, 1, 4);
        pulse_result(15'h0000);
        chk_line("R8 bit kept after stray valid", {1'b1, d[W-4]});
        read_bits(d, 5, W - 4);
        end_cycle();
    endtask

    task automatic t_sclk_busy();
        logic [W-1:0] d;
        d = 15'h4000;
        start_cycle(1'b1);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0;
            settle();
            chk_line("R9 sclk while busy", LL);
            sclk = 1'b1;
            settle();
        end
        pulse_result(d);
        chk_line("R9 ready after sclk", LH);
        read_bits(d, 1, W);
        end_cycle();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_full_read(15'h2B3C, 1'b0);
        t_full_read(15'h5555, 1'b1);
        t_abort_busy();
        t_abort_mid();
        t_ignore_valid();
        t_sclk_busy();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule